// File: doc/BRIEF.md
# Configurable Mantissa Rounding Unit

This stage takes a sign-magnitude floating-point value whose significand is wider than the target precision and reduces it to the target width. The extra low-order bits are folded into guard, round and sticky bits, and the retained significand is incremented or left alone according to one of four rounding directions: to nearest with ties to even, toward minus infinity, toward plus infinity, or toward zero.

The result goes through one register stage. The outputs are the rounded significand, the exponent, the unchanged sign and an inexact flag. The input significand is assumed to be normalised already. The only exponent adjustment the block makes is the one caused by a rounding increment that carries out of the top of the significand.

Top module: `mant_round_unit`

## Requirements
- R1: Outputs are registered with one cycle of latency. `valid_o` equals `valid_i` of the previous cycle. While `rst_ni` is low, `valid_o`, `sig_o`, `exp_o`, `sign_o` and `inexact_o` are all 0.
- R2: The discarded part is the low EXT_W bits of `sig_i`. `inexact_o` is 1 exactly when any of those bits is 1, in every mode.
- R3: With `mode_i` = 2'b00 (nearest), the kept part is incremented when the discarded part is greater than half of one kept LSB.
- R4: With `mode_i` = 2'b00, a discarded part of exactly one half (guard bit 1, all lower bits 0) increments only when the kept LSB is 1, so the result always has LSB 0.
- R5: With `mode_i` = 2'b01 (toward minus infinity), the magnitude is incremented only when `sign_i` is 1 and the result is inexact.
- R6: With `mode_i` = 2'b10 (toward plus infinity), the magnitude is incremented only when `sign_i` is 0 and the result is inexact.
- R7: With `mode_i` = 2'b11 (toward zero), `sig_o` is always the upper OUT_W bits of `sig_i`.
- R8: When an increment carries out of the OUT_W-bit significand, `sig_o` is 1 followed by zeros, and `exp_o` is `exp_i` + 1 modulo 2^EXP_W. Otherwise `exp_o` equals `exp_i`.
- R9: `sign_o` equals the `sign_i` of the captured input.
- R10: When the discarded part is zero, `sig_o` equals the upper bits of `sig_i` and `exp_o` equals `exp_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input value present |
| sign_i | input | 1 | Sign (1 = negative) |
| exp_i | input | EXP_W | Exponent |
| sig_i | input | OUT_W+EXT_W | Extended significand |
| mode_i | input | 2 | Rounding direction: 00 nearest, 01 down, 10 up, 11 toward zero |
| valid_o | output | 1 | Result present |
| sign_o | output | 1 | Result sign |
| exp_o | output | EXP_W | Adjusted exponent |
| sig_o | output | OUT_W | Rounded significand |
| inexact_o | output | 1 | Discarded bits were nonzero |

## Verification
Directed cases put the discarded part just below, exactly at, and just above one half, with both even and odd kept LSBs. This separates the ties-to-even rule from a plain add-half rounder. Each directed value is also run under both signs in all four modes, which shows whether the directed modes correctly depend on the sign. An all-ones significand forces the carry path, and zero tails confirm that exact values pass through unchanged. Random values cover the rest of the space and are compared against an integer comparison model.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/mr_grs_reduce.sv
module mr_grs_reduce #(
  parameter int EXT_W = 8
) (
  input  logic [EXT_W-1:0] tail_i,
  output logic             guard_o,
  output logic             round_o,
  output logic             sticky_o
);
  assign guard_o = tail_i[EXT_W-1];
  assign round_o = tail_i[EXT_W-2];
  generate
    if (EXT_W >= 3) begin : g_sticky
      assign sticky_o = |tail_i[EXT_W-3:0];
    end else begin : g_no_sticky
      assign sticky_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mr_round_decide.sv
module mr_round_decide
  import mr_pkg::*;
(
  input  rnd_mode_e mode_i,
  input  logic      sign_i,
  input  logic      lsb_i,
  input  logic      guard_i,
  input  logic      round_i,
  input  logic      sticky_i,
  output logic      inc_o,
  output logic      inexact_o
);
  logic lost;
  assign lost      = guard_i | round_i | sticky_i;
  assign inexact_o = lost;

  always_comb begin
    unique case (mode_i)
      RND_NEAR: inc_o = guard_i & (round_i | sticky_i | lsb_i);
      RND_DOWN: inc_o = sign_i & lost;
      RND_UP:   inc_o = ~sign_i & lost;
      default:  inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mr_sig_increment.sv
module mr_sig_increment #(
  parameter int OUT_W = 24,
  parameter int EXP_W = 8
) (
  input  logic [OUT_W-1:0] sig_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             inc_i,
  output logic [OUT_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o
);
  logic [OUT_W:0] sum;
  assign sum = {1'b0, sig_i} + {{OUT_W{1'b0}}, inc_i};

  always_comb begin
    if (sum[OUT_W]) begin
      sig_o = {1'b1, {(OUT_W-1){1'b0}}};
      exp_o = exp_i + {{(EXP_W-1){1'b0}}, 1'b1};
    end else begin
      sig_o = sum[OUT_W-1:0];
      exp_o = exp_i;
    end
  end
endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
  import mr_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int EXT_W = 8,
  parameter int EXP_W = 8,
  localparam int IN_W = OUT_W + EXT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [IN_W-1:0]  sig_i,
  input  logic [1:0]       mode_i,
  output logic             valid_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [OUT_W-1:0] sig_o,
  output logic             inexact_o
);
  logic [OUT_W-1:0] kept;
  logic guard, rnd, sticky, inc, inexact;
  logic [OUT_W-1:0] sig_n;
  logic [EXP_W-1:0] exp_n;
  rnd_mode_e mode;

  assign kept = sig_i[IN_W-1:EXT_W];
  assign mode = rnd_mode_e'(mode_i);

  mr_grs_reduce #(.EXT_W(EXT_W)) u_grs (
    .tail_i  (sig_i[EXT_W-1:0]),
    .guard_o (guard),
    .round_o (rnd),
    .sticky_o(sticky)
  );

  mr_round_decide u_dec (
    .mode_i   (mode),
    .sign_i   (sign_i),
    .lsb_i    (kept[0]),
    .guard_i  (guard),
    .round_i  (rnd),
    .sticky_i (sticky),
    .inc_o    (inc),
    .inexact_o(inexact)
  );

  mr_sig_increment #(.OUT_W(OUT_W), .EXP_W(EXP_W)) u_inc (
    .sig_i(kept),
    .exp_i(exp_i),
    .inc_i(inc),
    .sig_o(sig_n),
    .exp_o(exp_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sign_o    <= 1'b0;
      exp_o     <= '0;
      sig_o     <= '0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sign_o    <= sign_i;
        exp_o     <= exp_n;
        sig_o     <= sig_n;
        inexact_o <= inexact;
      end
    end
  end
endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
  parameter int OUT_W = 24,
  parameter int EXT_W = 8,
  parameter int EXP_W = 8,
  localparam int IN_W = OUT_W + EXT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             sign_i,
  input logic [EXP_W-1:0] exp_i,
  input logic [IN_W-1:0]  sig_i,
  input logic [1:0]       mode_i,
  input logic             valid_o,
  input logic             sign_o,
  input logic [EXP_W-1:0] exp_o,
  input logic [OUT_W-1:0] sig_o,
  input logic             inexact_o
);
  logic [OUT_W-1:0] kept;
  logic             tail_nz;
  assign kept    = sig_i[IN_W-1:EXT_W];
  assign tail_nz = |sig_i[EXT_W-1:0];

  assert_valid_pipe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_pipe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_inexact_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tail_nz) |=> inexact_o);
  assert_down_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01 && !sign_i) |=> sig_o == $past(kept));
  assert_up_neg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10 && sign_i) |=> sig_o == $past(kept));
  assert_trunc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b11) |=> sig_o == $past(kept));
  assert_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10 && !sign_i && (&kept) && tail_nz) |=>
      (sig_o == {1'b1, {(OUT_W-1){1'b0}}} &&
       exp_o == EXP_W'($past(exp_i) + 1'b1)));
  assert_sign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> sign_o == $past(sign_i));
  assert_exact_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !tail_nz) |=>
      (!inexact_o && sig_o == $past(kept) && exp_o == $past(exp_i)));
endmodule

bind mant_round_unit mant_round_chk #(
  .OUT_W(OUT_W), .EXT_W(EXT_W), .EXP_W(EXP_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sign_i(sign_i),
  .exp_i(exp_i), .sig_i(sig_i), .mode_i(mode_i), .valid_o(valid_o),
  .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o), .inexact_o(inexact_o)
);

// File: tb/mant_round_unit_tb.sv
module mant_round_unit_tb_top;
  localparam int OUT_W = 24;
  localparam int EXT_W = 8;
  localparam int EXP_W = 8;
  localparam int IN_W  = OUT_W + EXT_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, sign_i = 1'b0;
  logic [EXP_W-1:0] exp_i = '0;
  logic [IN_W-1:0]  sig_i = '0;
  logic [1:0]       mode_i = 2'b00;
  logic valid_o, sign_o, inexact_o;
  logic [EXP_W-1:0] exp_o;
  logic [OUT_W-1:0] sig_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mant_round_unit #(.OUT_W(OUT_W), .EXT_W(EXT_W), .EXP_W(EXP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .mode_i(mode_i), .valid_o(valid_o),
    .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o), .inexact_o(inexact_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: compare the discarded part against one half as integers.
  function automatic longint ref_sig(input logic s, input logic [1:0] m,
                                     input logic [IN_W-1:0] v, output longint e_inc,
                                     output bit inx);
    longint up, low, half, res;
    bit inc;
    up   = longint'(v >> EXT_W);
    low  = longint'(v) & ((longint'(1) << EXT_W) - 1);
    half = longint'(1) << (EXT_W - 1);
    inx  = (low != 0);
    case (m)
      2'b00:   inc = (low > half) || (low == half && up[0]);
      2'b01:   inc = s && inx;
      2'b10:   inc = !s && inx;
      default: inc = 1'b0;
    endcase
    res = up + longint'(inc);
    e_inc = 0;
    if (res == (longint'(1) << OUT_W)) begin
      res = longint'(1) << (OUT_W - 1);
      e_inc = 1;
    end
    return res;
  endfunction

  task automatic run(input logic s, input logic [1:0] m, input logic [IN_W-1:0] v,
                     input logic [EXP_W-1:0] e, input string tag);
    longint es, ei;
    bit ex;
    logic [EXP_W-1:0] ee;
    es = ref_sig(s, m, v, ei, ex);
    ee = e + EXP_W'(ei);
    @(negedge clk);
    valid_i = 1'b1; sign_i = s; mode_i = m; sig_i = v; exp_i = e;
    @(negedge clk);
    chk(sig_o == OUT_W'(es), {tag, " sig"}, longint'(sig_o), es);
    chk(exp_o == ee, "R8 exp", longint'(exp_o), longint'(ee));
    chk(inexact_o == ex, "R2 inexact", longint'(inexact_o), longint'(ex));
    chk(sign_o == s && valid_o, "R9/R1 sign valid", longint'({sign_o, valid_o}),
        longint'({s, 1'b1}));
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [OUT_W-1:0] k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!valid_o && sig_o == '0 && exp_o == '0 && !inexact_o && !sign_o, "R1 reset",
        longint'(sig_o), 0);
    rst_n = 1'b1;
    // Directed: 1.0111 pattern, kept ends 1.011, discarded 1 then zeros (tie, odd LSB)
    k = {4'b1011, {(OUT_W-4){1'b1}}};
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        run(s[0], m[1:0], {k, 8'h80}, 8'h10, "R4/R5/R6/R7 tie odd");
        run(s[0], m[1:0], {k - 1'b1, 8'h80}, 8'h10, "R4 tie even");
        run(s[0], m[1:0], {k, 8'h7F}, 8'h20, "R3 below half");
        run(s[0], m[1:0], {k, 8'h81}, 8'h20, "R3 above half");
        run(s[0], m[1:0], {{OUT_W{1'b1}}, 8'hC0}, 8'hFF, "R8 carry");
        run(s[0], m[1:0], {24'hA5A5A5, 8'h00}, 8'h33, "R10 exact");
        run(s[0], m[1:0], {24'h800000, 8'h01}, 8'h40, "R2 sticky only");
      end
    end
    // Idle cycle: valid_o must drop (R1)
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    chk(!valid_o, "R1 idle", longint'(valid_o), 0);
    // Random stimulus
    for (int n = 0; n < 3000; n++) begin
      run($urandom() & 1, 2'($urandom()), {$urandom() | 32'h8000_0000},
          8'($urandom()), "R3/R5/R6/R7 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule